// File: doc/BRIEF.md
# Polynomial Tone and Noise Channel

This block is one audio voice. A base-rate enable strobe, nominally near 30 kHz, first passes through a programmable divider. Each divided strobe then advances a set of waveform sources. These sources are three maximal-length shift-register generators (4, 5 and 9 stages) and a shared modulo counter that forms fixed division ratios. A 4-bit mode value selects which source, or which chained pair of sources, drives a single waveform bit. The 4-bit output amplitude equals the programmed volume while that bit is 1, and zero otherwise.

Software programs the voice through a small write port. A 2-bit select chooses among divider value, mode and volume. The mode becomes active only on a divided strobe, so that a waveform change lines up with the sound's own timing. Volume and divider writes act at once. Mixing of several voices and any analogue stage lie outside the block.

Top module: `poly_tone_channel`

## Requirements
- R1: With divider value F (0..31) written under select 0 (bits 4:0), one divided strobe occurs every F+1 base strobes. A square-wave mode therefore changes level every F+1 base strobes.
- R2: While the base strobe input is low, no state advances and the output sample does not change.
- R3: The sample equals the volume (select 2, bits 3:0) when the waveform bit is 1, and 0 when it is 0. Modes 0 and 11 force the waveform bit to 1. Volume 0 is silent.
- R4: Mode 1 gives a noise sequence of period 15 with 8 ones per period. Mode 9 gives period 31 with 16 ones. Mode 8 gives period 511 with 256 ones.
- R5: Fixed dividers, counted in divided strobes: modes 4 and 5 repeat every 2 with 1 high. Modes 12 and 13 repeat every 6 with 3 high. Modes 6 and 10 repeat every 31 with 16 high. Mode 14 repeats every 93 with 47 high.
- R6: Chained modes: mode 2 repeats every 225 with 120 ones, because the 4-stage generator is stepped once per 15 strobes. Mode 3 steps the 4-stage generator only when the 5-stage output is 1 (period 465). Mode 7 toggles a flip-flop on those same strobes (period 31). Mode 15 runs a divide-by-6 on them (period 93). None of these is constant.
- R7: A mode written under select 1 (bits 3:0) becomes active at the first divided strobe at or after the write cycle. A write in the very cycle of a strobe is active from that strobe. Until then the sample keeps following the old mode.
- R8: After reset, the divider value, mode and volume are 0 and the sample is 0. No generator ever holds all zeros.
- R9: Volume and divider writes take effect from the clock edge that accepts them, without waiting for a divided strobe.
- R10: If the divider value is written below the divider's current count, the next base strobe produces a divided strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base-rate enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 divider, 1 mode, 2 volume, 3 none |
| wr_data | input | 5 | Write data |
| sample | output | 4 | Output amplitude |

## Verification
A mode write and a divided strobe can fall in the same clock. The bench uses a square-wave mode with divider value 3 and locks onto a rising output edge, which places the next strobe exactly four clocks later. It then writes a forced-high mode either in that strobe's cycle or one cycle after it. In the first case the output must stay high through the strobe. In the second case the output must drop with the strobe and return high only at the following strobe, four clocks on.

// File: rtl/poly_tone_channel.sv
module poly_tone_channel #(
  parameter int FREQ_W = 5,
  parameter int VOL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [FREQ_W-1:0] wr_data,
  output logic [VOL_W-1:0]  sample
);
  localparam int MODE_W = 4;
  localparam int PH_W   = 7;

  logic [FREQ_W-1:0] freq_q, div_q;
  logic [MODE_W-1:0] mode_q, mode_act;
  logic [VOL_W-1:0]  vol_q;
  logic [3:0]        p4;
  logic [4:0]        p5;
  logic [8:0]        p9;
  logic [PH_W-1:0]   phase, ph_mod, ph_half;
  logic              t2, wave, ph_en, p4_en, ph_wrap;

  wire wr_mode = wr_en && (wr_sel == 2'd1);
  wire [MODE_W-1:0] mode_nxt = wr_mode ? wr_data[MODE_W-1:0] : mode_q;
  wire st = tick && (div_q >= freq_q);

  always_comb begin
    case (mode_act)
      4'd2:                      ph_mod = 7'd15;
      4'd6, 4'd10:               ph_mod = 7'd31;
      4'd12, 4'd13, 4'd15:       ph_mod = 7'd6;
      4'd14:                     ph_mod = 7'd93;
      default:                   ph_mod = 7'd2;
    endcase
  end

  assign ph_half = (ph_mod + 7'd1) >> 1;
  assign ph_wrap = phase >= (ph_mod - 7'd1);
  assign ph_en   = (mode_act == 4'd15) ? p5[0] : 1'b1;

  always_comb begin
    case (mode_act)
      4'd2:    p4_en = ph_wrap;
      4'd3:    p4_en = p5[0];
      default: p4_en = 1'b1;
    endcase
  end

  always_comb begin
    case (mode_act)
      4'd1, 4'd2, 4'd3:                   wave = p4[0];
      4'd7:                               wave = t2;
      4'd8:                               wave = p9[0];
      4'd9:                               wave = p5[0];
      4'd4, 4'd5, 4'd6, 4'd10,
      4'd12, 4'd13, 4'd14, 4'd15:         wave = phase < ph_half;
      default:                            wave = 1'b1;
    endcase
  end

  assign sample = wave ? vol_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_q   <= '0;
      div_q    <= '0;
      mode_q   <= '0;
      mode_act <= '0;
      vol_q    <= '0;
      p4       <= '1;
      p5       <= '1;
      p9       <= '1;
      phase    <= '0;
      t2       <= 1'b1;
    end else begin
      if (wr_en && wr_sel == 2'd0) freq_q <= wr_data;
      if (wr_mode)                 mode_q <= wr_data[MODE_W-1:0];
      if (wr_en && wr_sel == 2'd2) vol_q  <= wr_data[VOL_W-1:0];
      if (tick) div_q <= st ? '0 : div_q + 1'b1;
      if (st) begin
        mode_act <= mode_nxt;
        p5 <= {p5[3:0], p5[4] ^ p5[2]};
        p9 <= {p9[7:0], p9[8] ^ p9[4]};
        if (p4_en) p4 <= {p4[2:0], p4[3] ^ p4[2]};
        if (ph_en) phase <= ph_wrap ? '0 : phase + 7'd1;
        if (mode_act == 4'd7 && p5[0]) t2 <= ~t2;
      end
    end
  end

  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(div_q) && $stable(wave) && $stable(p5));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !st |=> $stable(wave) && $stable(mode_act));
  a_r8_live: assert property (@(posedge clk) disable iff (!rst_n)
    (p4 != 4'd0) && (p5 != 5'd0) && (p9 != 9'd0));
  a_r5_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase < 7'd93);
  a_r3_forced: assert property (@(posedge clk) disable iff (!rst_n)
    st && (mode_nxt == 4'd0 || mode_nxt == 4'd11) |=> wave);
endmodule

// File: tb/poly_tone_channel_test.sv
module poly_tone_channel_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [4:0] wr_data = '0;
  logic [3:0] sample;
  int checks = 0, fails = 0;
  bit cap [0:1023];

  poly_tone_channel uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .sample(sample));

  always #4 clk = ~clk;

  localparam logic [11:0] VEC [8] = '{
    {4'd0, 4'd15, 4'd15}, {4'd0, 4'd0, 4'd0}, {4'd0, 4'd7, 4'd7}, {4'd11, 4'd1, 4'd1},
    {4'd11, 4'd9, 4'd9},  {4'd0, 4'd5, 4'd5}, {4'd11, 4'd0, 4'd0}, {4'd11, 4'd15, 4'd15}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [4:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic gap(bit half, output int n);
    bit prev;
    n = 0;
    prev = sample != 0;
    do begin @(negedge clk); if (half) tick = ~tick; end while ((sample != 0) == prev);
    prev = sample != 0;
    do begin @(negedge clk); if (half) tick = ~tick; n++; end
      while ((sample != 0) == prev && n < 200);
    tick = 1'b1;
  endtask

  task automatic rise_sync();
    bit prev;
    int guard = 0;
    prev = sample != 0;
    while (!(prev == 1'b0 && sample != 0) && guard < 300) begin
      prev = sample != 0; @(negedge clk); guard++;
    end
  endtask

  task automatic capture(logic [4:0] mode, int per, int ones_exp, string req);
    int ones = 0, bad = 0, chg = 0;
    wr(2'd1, mode);
    repeat (200) @(negedge clk);
    for (int i = 0; i < 2 * per; i++) begin
      cap[i] = sample != 0;
      if (sample != 0 && sample != 4'd15) bad++;
      @(negedge clk);
    end
    for (int i = 0; i < per; i++) begin
      if (cap[i] != cap[i + per]) bad++;
      if (cap[i]) ones++;
      if (i > 0 && cap[i] != cap[i - 1]) chg++;
    end
    chk({req, " periodicity"}, bad, 0);
    chk({req, " not constant"}, int'(chg > 0), 1);
    if (ones_exp >= 0) chk({req, " ones per period"}, ones, ones_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit held;
    logic [3:0] s0;
    repeat (3) @(negedge clk);
    chk("R8 sample in reset", sample, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 sample after reset", sample, 0);
    wr(2'd2, 5'd9);
    chk("R8 default mode 0 with volume 9 (R9 immediate)", sample, 9);

    for (int v = 0; v < 8; v++) begin
      wr(2'd1, {1'b0, VEC[v][11:8]});
      wr(2'd2, {1'b0, VEC[v][7:4]});
      @(negedge clk);
      chk($sformatf("R3 vector %0d", v), sample, VEC[v][3:0]);
    end

    wr(2'd2, 5'd15);
    wr(2'd1, 5'd4);
    foreach (VEC[k]) begin
      if (k < 3) begin
        automatic int f = (k == 0) ? 0 : (k == 1) ? 5 : 31;
        wr(2'd0, f[4:0]);
        gap(1'b0, n); gap(1'b0, n);
        chk($sformatf("R1 full rate F=%0d", f), n, f + 1);
        gap(1'b1, n); gap(1'b1, n);
        chk($sformatf("R1 half rate F=%0d", f), n, 2 * (f + 1));
      end
    end

    wr(2'd0, 5'd0);
    wr(2'd1, 5'd1);
    repeat (5) @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    s0 = sample; held = 1'b1;
    repeat (20) begin @(negedge clk); if (sample != s0) held = 1'b0; end
    chk("R2 frozen without base strobe", int'(held), 1);
    tick = 1'b1;

    wr(2'd0, 5'd3);
    wr(2'd1, 5'd4);
    rise_sync();
    repeat (3) @(negedge clk);
    wr_sel = 2'd1; wr_data = 5'd0; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
    chk("R7 write coincident with strobe", sample, 15);

    wr(2'd1, 5'd4);
    repeat (12) @(negedge clk);
    rise_sync();
    repeat (4) @(negedge clk);
    chk("R7 square dropped at strobe", sample, 0);
    wr(2'd1, 5'd0);
    held = sample == 0;
    repeat (2) begin @(negedge clk); if (sample != 0) held = 1'b0; end
    chk("R7 old mode kept until strobe", int'(held), 1);
    @(negedge clk);
    chk("R7 new mode at next strobe", sample, 15);

    wr(2'd1, 5'd4);
    wr(2'd0, 5'd31);
    gap(1'b0, n);
    repeat (5) @(negedge clk);
    s0 = sample;
    wr(2'd0, 5'd0);
    chk("R10 no strobe on write edge", sample, s0);
    @(negedge clk);
    chk("R10 strobe on next base strobe", int'(sample != s0), 1);

    wr(2'd0, 5'd0);
    capture(5'd1, 15, 8, "R4 mode 1");
    capture(5'd9, 31, 16, "R4 mode 9");
    capture(5'd8, 511, 256, "R4 mode 8");
    capture(5'd4, 2, 1, "R5 mode 4");
    capture(5'd5, 2, 1, "R5 mode 5");
    capture(5'd12, 6, 3, "R5 mode 12");
    capture(5'd13, 6, 3, "R5 mode 13");
    capture(5'd6, 31, 16, "R5 mode 6");
    capture(5'd10, 31, 16, "R5 mode 10");
    capture(5'd14, 93, 47, "R5 mode 14");
    capture(5'd2, 225, 120, "R6 mode 2");
    capture(5'd3, 465, -1, "R6 mode 3");
    capture(5'd7, 31, -1, "R6 mode 7");
    capture(5'd15, 93, -1, "R6 mode 15");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule